// File: doc/BRIEF.md
# Dual-Output Serial Flash Read Engine

This block is the device side of a serial flash emulator, limited to the read path. A system clock runs much faster than the serial clock and oversamples the four serial pins. The block captures an 8-bit opcode and a 24-bit start address. It then streams bytes from an internal array whose address advances after every byte, until chip select is released. Three opcodes are served. The plain read sends data as soon as the address is complete. The fast read inserts a fixed run of dummy clocks first. The dual fast read adds the same dummy clocks, then turns the shared input line into a second output and moves two bits per serial clock.

Edges of the serial clock are found in the system-clock domain, so clock polarity 0 and polarity 3 both work without configuration. Array contents come from a fixed address-to-byte function, so the array needs no storage and no fill path. Each output has its own enable, and the pad logic around the block does the tri-stating.

Top module: `sflash_rd_engine`

## Requirements
- R1: After reset, and from two system cycles after chip select is seen high, `do_oe` and `dio_oe` are both 0.
- R2: While chip select is low, the first 8 bits sampled on rising serial-clock edges form the opcode, most significant bit first. The codes 0x03, 0x0B and 0x3B are recognised.
- R3: After opcode 0x03 the next 24 rising edges carry the start address, high bit first. From the first falling edge after the last address bit, each byte appears on `do_out` most significant bit first, one bit per falling edge, with `do_oe` high and `dio_oe` low.
- R4: After opcode 0x0B and the address, `DUMMY_CLKS` (default 8) rising edges pass with `dio_in` ignored. Data then follows on `do_out` as in R3.
- R5: After opcode 0x3B and the dummy clocks, each falling edge drives two bits. The order per byte is bits 7,5,3,1 on `do_out` and bits 6,4,2,0 on `dio_out`, so one byte takes four clocks. `dio_oe` is high only during this data phase, and never without `do_oe`.
- R6: The address advances by one after every byte, and the stream continues for as long as chip select stays low.
- R7: Only the low log2(`DEPTH`) address bits are used, with `DEPTH` a power of two (default 4096). The address wraps from `DEPTH-1` to 0.
- R8: Serial-clock idle level 0 or 1 while chip select is high both give identical data. A falling edge before the data phase has no effect.
- R9: Any other opcode keeps both enables at 0 until chip select rises. The next command after that is served normally.
- R10: The byte at array address a (a zero-extended to 24 bits) is ((a[7:0]*37 + 11) mod 256) XOR a[15:8] XOR a[23:16] XOR `SEED` (default 0x5A).
- R11: A read may end after any bit. The next command starts cleanly from its own address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_csn | input | 1 | Active-low chip select |
| dio_in | input | 1 | Serial data into the block (opcode, address, dummy) |
| do_out | output | 1 | Primary serial data out |
| do_oe | output | 1 | Drive enable for `do_out` |
| dio_out | output | 1 | Second data bit in dual mode |
| dio_oe | output | 1 | Drive enable for `dio_out` |

## Verification
The hardest moment to reach is the falling edge that directly follows the last address or dummy bit. The first data bit must already appear there, and in polarity 3 a stray falling edge also arrives just after chip select drops. Directed reads cover both clock polarities, a dual read across the array wrap, a bad opcode and a read cut off mid-byte. Seeded random reads then mix opcode, address, length and polarity, so that the first-bit edge is hit under every combination.

// File: rtl/sfre_pkg.sv
package sfre_pkg;

   typedef enum logic [2:0] {
      ST_CMD,
      ST_ADDR,
      ST_DUMMY,
      ST_DATA,
      ST_BAD
   } phase_t;

   localparam logic [7:0] OP_READ = 8'h03;
   localparam logic [7:0] OP_FAST = 8'h0B;
   localparam logic [7:0] OP_DUAL = 8'h3B;

   // address-to-byte function standing in for the array contents
   function automatic logic [7:0] pattern_byte(input logic [23:0] a, input logic [7:0] seed);
      logic [7:0] t;
      t = a[7:0] * 8'd37 + 8'd11;
      return t ^ a[15:8] ^ a[23:16] ^ seed;
   endfunction

endpackage

// File: rtl/sfre_pin_sync.sv
module sfre_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_i,
   input  logic csn_i,
   input  logic din_i,
   output logic sclk_rise,
   output logic sclk_fall,
   output logic cs_idle,
   output logic din_s
);
   localparam int MSB = STAGES - 1;

   logic [MSB:0] sclk_p;
   logic [MSB:0] csn_p;
   logic [MSB:0] din_p;
   logic         sclk_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_p <= '0;
         csn_p  <= '1;
         din_p  <= '0;
         sclk_d <= 1'b0;
      end else begin
         sclk_p <= {sclk_p[MSB-1:0], sclk_i};
         csn_p  <= {csn_p[MSB-1:0], csn_i};
         din_p  <= {din_p[MSB-1:0], din_i};
         sclk_d <= sclk_p[MSB];
      end
   end

   assign sclk_rise = sclk_p[MSB] & ~sclk_d;
   assign sclk_fall = ~sclk_p[MSB] & sclk_d;
   assign cs_idle   = csn_p[MSB];
   assign din_s     = din_p[MSB];

endmodule

// File: rtl/sfre_cmd_fsm.sv
module sfre_cmd_fsm
   import sfre_pkg::*;
#(
   parameter int AW         = 12,
   parameter int DUMMY_CLKS = 8,
   parameter bit DUAL_EN    = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_idle,
   input  logic          sclk_rise,
   input  logic          din_s,
   output phase_t        phase,
   output logic          dual,
   output logic [AW-1:0] addr
);
   localparam int ADDR_BITS = 24;
   localparam int CW = $clog2((ADDR_BITS > DUMMY_CLKS) ? ADDR_BITS : DUMMY_CLKS);

   logic [6:0]    op_sh;
   logic [7:0]    op_now;
   logic [CW-1:0] cnt;
   logic          fast;

   assign op_now = {op_sh, din_s};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= ST_CMD;
         op_sh <= '0;
         cnt   <= '0;
         fast  <= 1'b0;
         dual  <= 1'b0;
         addr  <= '0;
      end else if (cs_idle) begin
         phase <= ST_CMD;
         op_sh <= '0;
         cnt   <= '0;
         fast  <= 1'b0;
         dual  <= 1'b0;
      end else if (sclk_rise) begin
         case (phase)
            ST_CMD: begin
               op_sh <= op_now[6:0];
               if (cnt == CW'(7)) begin
                  cnt <= '0;
                  if (op_now == OP_READ) begin
                     phase <= ST_ADDR;
                  end else if (op_now == OP_FAST) begin
                     phase <= ST_ADDR;
                     fast  <= 1'b1;
                  end else if (op_now == OP_DUAL && DUAL_EN) begin
                     phase <= ST_ADDR;
                     fast  <= 1'b1;
                     dual  <= 1'b1;
                  end else begin
                     phase <= ST_BAD;
                  end
               end else begin
                  cnt <= cnt + CW'(1);
               end
            end
            ST_ADDR: begin
               addr <= {addr[AW-2:0], din_s};
               if (cnt == CW'(ADDR_BITS - 1)) begin
                  cnt   <= '0;
                  phase <= fast ? ST_DUMMY : ST_DATA;
               end else begin
                  cnt <= cnt + CW'(1);
               end
            end
            ST_DUMMY: begin
               if (cnt == CW'(DUMMY_CLKS - 1)) begin
                  cnt   <= '0;
                  phase <= ST_DATA;
               end else begin
                  cnt <= cnt + CW'(1);
               end
            end
            default: ;
         endcase
      end
   end

   p_dummy_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == ST_DUMMY) |-> (cnt < CW'(DUMMY_CLKS)));

endmodule

// File: rtl/sfre_out_serializer.sv
module sfre_out_serializer #(
   parameter int         AW      = 12,
   parameter bit         DUAL_EN = 1'b1,
   parameter logic [7:0] SEED    = 8'h5A
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_idle,
   input  logic          sclk_fall,
   input  logic          in_data,
   input  logic          dual,
   input  logic [AW-1:0] start_addr,
   output logic          do_out,
   output logic          do_oe,
   output logic          dio_out,
   output logic          dio_oe
);
   logic [AW-1:0] rd_addr;
   logic [AW-1:0] cur_addr;
   logic [7:0]    sh;
   logic [7:0]    byte_now;
   logic [2:0]    idx;
   logic          started;
   logic          dual_eff;
   logic          step;

   assign dual_eff = DUAL_EN && dual;
   assign step     = in_data && sclk_fall;

   always_comb begin
      cur_addr = started ? rd_addr : start_addr;
      byte_now = (idx == 3'd0) ? sfre_pkg::pattern_byte(24'(cur_addr), SEED) : sh;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_addr <= '0;
         sh      <= '0;
         idx     <= '0;
         started <= 1'b0;
         do_out  <= 1'b0;
         do_oe   <= 1'b0;
      end else if (cs_idle) begin
         sh      <= '0;
         idx     <= '0;
         started <= 1'b0;
         do_out  <= 1'b0;
         do_oe   <= 1'b0;
      end else if (step) begin
         started <= 1'b1;
         do_oe   <= 1'b1;
         do_out  <= byte_now[7];
         if (idx == 3'd0) rd_addr <= cur_addr + 1'b1;
         if (dual_eff) begin
            sh  <= byte_now << 2;
            idx <= (idx == 3'd3) ? 3'd0 : idx + 3'd1;
         end else begin
            sh  <= byte_now << 1;
            idx <= idx + 3'd1;
         end
      end
   end

   generate
      if (DUAL_EN) begin : g_dual
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               dio_out <= 1'b0;
               dio_oe  <= 1'b0;
            end else if (cs_idle) begin
               dio_out <= 1'b0;
               dio_oe  <= 1'b0;
            end else if (step && dual_eff) begin
               dio_out <= byte_now[6];
               dio_oe  <= 1'b1;
            end
         end
      end else begin : g_single
         assign dio_out = 1'b0;
         assign dio_oe  = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/sflash_rd_engine.sv
module sflash_rd_engine
   import sfre_pkg::*;
#(
   parameter int         DEPTH       = 4096,
   parameter int         DUMMY_CLKS  = 8,
   parameter int         SYNC_STAGES = 2,
   parameter bit         DUAL_EN     = 1'b1,
   parameter logic [7:0] SEED        = 8'h5A
) (
   input  logic clk,
   input  logic rst_n,
   input  logic spi_sclk,
   input  logic spi_csn,
   input  logic dio_in,
   output logic do_out,
   output logic do_oe,
   output logic dio_out,
   output logic dio_oe
);
   localparam int AW = $clog2(DEPTH);

   initial begin
      assert (DEPTH >= 4 && (DEPTH & (DEPTH - 1)) == 0 && AW <= 24)
         else $error("DEPTH must be a power of two between 4 and 2^24");
      assert (DUMMY_CLKS >= 1 && DUMMY_CLKS <= 32)
         else $error("DUMMY_CLKS out of range");
      assert (SYNC_STAGES >= 2)
         else $error("SYNC_STAGES must be at least 2");
   end

   logic          sclk_rise;
   logic          sclk_fall;
   logic          cs_idle;
   logic          din_s;
   phase_t        phase;
   logic          dual;
   logic [AW-1:0] start_addr;

   sfre_pin_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .sclk_i    (spi_sclk),
      .csn_i     (spi_csn),
      .din_i     (dio_in),
      .sclk_rise (sclk_rise),
      .sclk_fall (sclk_fall),
      .cs_idle   (cs_idle),
      .din_s     (din_s)
   );

   sfre_cmd_fsm #(.AW(AW), .DUMMY_CLKS(DUMMY_CLKS), .DUAL_EN(DUAL_EN)) fsm_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_idle   (cs_idle),
      .sclk_rise (sclk_rise),
      .din_s     (din_s),
      .phase     (phase),
      .dual      (dual),
      .addr      (start_addr)
   );

   sfre_out_serializer #(.AW(AW), .DUAL_EN(DUAL_EN), .SEED(SEED)) ser_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_idle    (cs_idle),
      .sclk_fall  (sclk_fall),
      .in_data    (phase == ST_DATA),
      .dual       (dual),
      .start_addr (start_addr),
      .do_out     (do_out),
      .do_oe      (do_oe),
      .dio_out    (dio_out),
      .dio_oe     (dio_oe)
   );

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cs_idle |=> (!do_oe && !dio_oe));

   p_dio_with_do_r5: assert property (@(posedge clk) disable iff (!rst_n)
      dio_oe |-> do_oe);

   p_bad_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == ST_BAD) |-> (!do_oe && !dio_oe));

   p_do_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (do_oe && $past(do_oe) && !$stable(do_out)) |-> $past(sclk_fall));

endmodule

// File: tb/sflash_rd_engine_tb_top.sv
module sflash_rd_engine_tb_top;
   localparam int DEPTH = 4096;
   localparam int HALF  = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b0;
   logic csn = 1'b1;
   logic dio_in = 1'b0;
   logic do_out, do_oe, dio_out, dio_oe;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;
   bit summary_done = 1'b0;
   logic s_do, s_dio, s_do_oe, s_dio_oe;

   always #2 clk = ~clk;

   sflash_rd_engine dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .spi_sclk (sclk),
      .spi_csn  (csn),
      .dio_in   (dio_in),
      .do_out   (do_out),
      .do_oe    (do_oe),
      .dio_out  (dio_out),
      .dio_oe   (dio_oe)
   );

   function automatic logic [7:0] exp_byte(input logic [23:0] a);
      logic [23:0] m;
      logic [7:0]  t;
      m = a & 24'(DEPTH - 1);
      t = m[7:0] * 8'd37 + 8'd11;
      return t ^ m[15:8] ^ m[23:16] ^ 8'h5A;
   endfunction

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      if (!summary_done) begin
         summary_done = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      end
   endtask

   task automatic spi_clk(input logic b);
      sclk = 1'b0;
      dio_in = b;
      wt(HALF);
      s_do = do_out;
      s_dio = dio_out;
      s_do_oe = do_oe;
      s_dio_oe = dio_oe;
      sclk = 1'b1;
      wt(HALF);
   endtask

   task automatic begin_txn(input bit mode3);
      sclk = mode3;
      wt(HALF);
      csn = 1'b0;
      wt(HALF);
   endtask

   task automatic end_txn(input bit mode3);
      if (!mode3) sclk = 1'b0;
      wt(HALF);
      csn = 1'b1;
      wt(2 * HALF);
      chk(!do_oe && !dio_oe, "R1", {do_oe, dio_oe}, 0);
   endtask

   task automatic send_header(input logic [7:0] op, input logic [23:0] addr);
      for (int i = 7; i >= 0; i--) spi_clk(op[i]);
      for (int i = 23; i >= 0; i--) spi_clk(addr[i]);
      if (op != 8'h03)
         for (int i = 0; i < 8; i++) spi_clk(1'($urandom_range(0, 1)));
   endtask

   task automatic run_read(input logic [7:0] op, input logic [23:0] addr, input int nbytes,
                           input bit mode3, input string tag);
      bit dual;
      logic [7:0] got, exp;
      bit oe_ok;
      dual = (op == 8'h3B);
      begin_txn(mode3);
      send_header(op, addr);
      for (int b = 0; b < nbytes; b++) begin
         got = '0;
         oe_ok = 1'b1;
         if (dual) begin
            for (int k = 0; k < 4; k++) begin
               spi_clk(1'($urandom_range(0, 1)));
               got[7 - 2 * k] = s_do;
               got[6 - 2 * k] = s_dio;
               oe_ok = oe_ok && s_do_oe && s_dio_oe;
            end
         end else begin
            for (int k = 0; k < 8; k++) begin
               spi_clk(1'b0);
               got[7 - k] = s_do;
               oe_ok = oe_ok && s_do_oe && !s_dio_oe;
            end
         end
         exp = exp_byte(addr + 24'(b));
         chk(got === exp, tag, got, exp);
         chk(oe_ok, dual ? "R5" : "R3", oe_ok, 1);
      end
      end_txn(mode3);
   endtask

   initial begin
      logic [7:0]  op;
      logic [23:0] a;
      bit any_oe;
      void'($urandom(32'h1234_5678));
      wt(5);
      rst_n = 1'b1;
      wt(4);
      chk(!do_oe && !dio_oe, "R1", {do_oe, dio_oe}, 0);

      run_read(8'h03, 24'h000010, 3, 1'b0, "R10");
      run_read(8'h03, 24'h000123, 2, 1'b0, "R3");
      run_read(8'h0B, 24'h000400, 3, 1'b0, "R4");
      run_read(8'h3B, 24'h000777, 3, 1'b0, "R5");
      run_read(8'h03, 24'h000200, 20, 1'b0, "R6");
      run_read(8'h03, 24'(DEPTH - 3), 6, 1'b0, "R7");
      run_read(8'h3B, 24'(DEPTH - 2), 4, 1'b0, "R7");
      run_read(8'h0B, 24'hABC123, 2, 1'b0, "R7");
      run_read(8'h03, 24'h000055, 2, 1'b1, "R8");
      run_read(8'h3B, 24'h000ABC, 3, 1'b1, "R8");

      // unrecognised opcode: enables stay off through many clocks
      begin_txn(1'b0);
      for (int i = 7; i >= 0; i--) spi_clk(1'(8'h9F >> i));
      any_oe = 1'b0;
      for (int i = 0; i < 48; i++) begin
         spi_clk(1'($urandom_range(0, 1)));
         any_oe = any_oe || s_do_oe || s_dio_oe;
      end
      chk(!any_oe, "R9", any_oe, 0);
      end_txn(1'b0);
      run_read(8'h0B, 24'h000321, 2, 1'b0, "R9");

      // read cut off after 5 data bits, then a fresh command
      begin_txn(1'b1);
      send_header(8'h03, 24'h000900);
      for (int i = 0; i < 5; i++) spi_clk(1'b0);
      end_txn(1'b1);
      run_read(8'h3B, 24'h000A00, 2, 1'b0, "R11");

      for (int t = 0; t < 36; t++) begin
         case ($urandom_range(0, 2))
            0: op = 8'h03;
            1: op = 8'h0B;
            default: op = 8'h3B;
         endcase
         a = 24'($urandom);
         run_read(op, a, $urandom_range(1, 5), 1'($urandom_range(0, 1)), "R2");
      end

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         summary();
         $finish;
      end
   end

endmodule